// File: doc/BRIEF.md
# Packed Signed Halfword Multiplier

This unit multiplies two 64-bit operands lane by lane, each operand holding four signed 16-bit values. A single array of four 16x16 signed multipliers feeds three output formats chosen by an opcode: the bottom half of every 32-bit lane product, the top half of every lane product, or a dot-product style reduction that adds neighbouring products into two 32-bit sums.

Work is issued with a one-cycle `start` pulse together with the opcode and both operands. The result comes back exactly two clock cycles later, marked by a one-cycle `outValid` pulse. A new operation may be issued on every cycle, so the unit behaves as a two-stage pipeline with a throughput of one operation per clock. Between valid pulses the result bus keeps its last value.

Top module: `pmul16_unit`

## Requirements
- R1: Each operand carries four signed two's-complement 16-bit lanes; lane i occupies bits 16*i+15 down to 16*i, and each lane product is the full signed 32-bit product of the matching lanes.
- R2: With opcode 2'b00, result lane i (bits 16*i+15:16*i) holds bits 15:0 of lane product i.
- R3: With opcode 2'b01, result lane i (bits 16*i+15:16*i) holds bits 31:16 of lane product i.
- R4: With opcode 2'b10, result bits 31:0 hold product 0 plus product 1, and bits 63:32 hold product 2 plus product 3, each sum taken modulo 2^32.
- R5: In opcode 2'b10, a pair whose four input lanes are all -32768 (0x8000) yields 0x80000000 for that 32-bit half.
- R6: A `start` accepted on clock edge k produces a one-cycle `outValid` pulse on edge k+2 carrying its result; starts on consecutive cycles yield results on consecutive cycles in issue order.
- R7: While `outValid` is low, `result` keeps the value it had at the previous edge.
- R8: Opcode 2'b11 produces an all-zero result.
- R9: While `rstN` is low, `outValid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe for one operation |
| opcode | input | 2 | Output format select |
| opA | input | 64 | First operand, four signed 16-bit lanes |
| opB | input | 64 | Second operand, four signed 16-bit lanes |
| outValid | output | 1 | One-cycle pulse marking a fresh result |
| result | output | 64 | Result of the operation issued two cycles earlier |

## Verification
The assertions compare the output against operands and opcode sampled two cycles before, so they assume `opA`, `opB` and `opcode` are meaningful only on a cycle where `start` is high and that the unit has run at least two cycles since reset. The stimulus keeps to that by driving inputs only on the falling edge, holding `start` low throughout reset, and mixing single issues, idle gaps and back-to-back bursts across all four opcodes, including the extreme lane values 0x8000 and 0x7FFF.

// File: rtl/pmul16_pkg.sv
package pmul16_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 16;

  typedef enum logic [1:0] {
    OP_LOW  = 2'b00,
    OP_HIGH = 2'b01,
    OP_DOT  = 2'b10,
    OP_NONE = 2'b11
  } opSel_e;

  typedef struct packed {
    logic   capture;
    logic   retire;
    opSel_e mode;
  } stageCtl_t;
endpackage

// File: rtl/pmul16_ctrl.sv
module pmul16_ctrl
  import pmul16_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic [1:0] opcode,
  output stageCtl_t ctl,
  output logic      outValid
);
  logic   s1Valid;
  opSel_e s1Mode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Mode   <= OP_LOW;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= start;
      if (start) s1Mode <= opSel_e'(opcode);
      outValid <= s1Valid;
    end
  end

  always_comb begin
    ctl.capture = start;
    ctl.retire  = s1Valid;
    ctl.mode    = s1Mode;
  end
endmodule

// File: rtl/pmul16_dp.sv
module pmul16_dp
  import pmul16_pkg::*;
#(
  parameter int NUM_LANES = LANES,
  parameter int LW        = LANE_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stageCtl_t               ctl,
  input  logic [NUM_LANES*LW-1:0] opA,
  input  logic [NUM_LANES*LW-1:0] opB,
  output logic [NUM_LANES*LW-1:0] result
);
  localparam int PW    = 2 * LW;
  localparam int PAIRS = NUM_LANES / 2;
  localparam int BUS_W = NUM_LANES * LW;

  logic signed [PW-1:0] prodD [NUM_LANES];
  logic signed [PW-1:0] prodQ [NUM_LANES];
  logic [BUS_W-1:0] lowVec, highVec, dotVec, nextResult;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic signed [PW-1:0] aExt, bExt;
    assign aExt = {{LW{opA[i*LW+LW-1]}}, opA[i*LW +: LW]};
    assign bExt = {{LW{opB[i*LW+LW-1]}}, opB[i*LW +: LW]};
    assign prodD[i] = aExt * bExt;

    always_ff @(posedge clk) begin
      if (!rstN)            prodQ[i] <= '0;
      else if (ctl.capture) prodQ[i] <= prodD[i];
    end

    assign lowVec[i*LW +: LW]  = prodQ[i][LW-1:0];
    assign highVec[i*LW +: LW] = prodQ[i][PW-1:LW];
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign dotVec[p*PW +: PW] = prodQ[2*p] + prodQ[2*p+1];
  end

  always_comb begin
    unique case (ctl.mode)
      OP_LOW:  nextResult = lowVec;
      OP_HIGH: nextResult = highVec;
      OP_DOT:  nextResult = dotVec;
      default: nextResult = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           result <= '0;
    else if (ctl.retire) result <= nextResult;
  end
endmodule

// File: rtl/pmul16_unit.sv
module pmul16_unit
  import pmul16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  opcode,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  output logic        outValid,
  output logic [63:0] result
);
  stageCtl_t ctl;

  pmul16_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opcode   (opcode),
    .ctl      (ctl),
    .outValid (outValid)
  );

  pmul16_dp #(.NUM_LANES(LANES), .LW(LANE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );
endmodule

// File: rtl/pmul16_unit_chk.sv
module pmul16_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [1:0]  opcode,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic        outValid,
  input logic [63:0] result
);
  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN)            upCnt <= 2'd0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end
  logic warm1, warm2;
  assign warm1 = (upCnt >= 2'd1);
  assign warm2 = (upCnt >= 2'd2);

  logic signed [31:0] pp [4];
  for (genvar i = 0; i < 4; i++) begin : g_ref
    assign pp[i] = $signed({{16{opA[16*i+15]}}, opA[16*i +: 16]}) *
                   $signed({{16{opB[16*i+15]}}, opB[16*i +: 16]});
    // R2: low halves, per lane
    a_r2_low_lane: assert property (@(posedge clk) disable iff (!rstN)
      (warm2 && outValid && $past(opcode, 2) == 2'b00) |->
        result[16*i +: 16] == $past(pp[i][15:0], 2));
    // R3: high halves, per lane
    a_r3_high_lane: assert property (@(posedge clk) disable iff (!rstN)
      (warm2 && outValid && $past(opcode, 2) == 2'b01) |->
        result[16*i +: 16] == $past(pp[i][31:16], 2));
  end

  logic [31:0] sumLo, sumHi;
  assign sumLo = pp[0] + pp[1];
  assign sumHi = pp[2] + pp[3];

  a_r4_dot_sum: assert property (@(posedge clk) disable iff (!rstN)
    (warm2 && outValid && $past(opcode, 2) == 2'b10) |->
      result == {$past(sumHi, 2), $past(sumLo, 2)});

  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    warm2 |-> (outValid == $past(start, 2)));

  a_r6_no_early: assert property (@(posedge clk) disable iff (!rstN)
    !warm2 |-> !outValid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (warm1 && !outValid) |-> $stable(result));

  a_r8_zero: assert property (@(posedge clk) disable iff (!rstN)
    (warm2 && outValid && $past(opcode, 2) == 2'b11) |-> result == 64'd0);
endmodule

bind pmul16_unit pmul16_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
  .opA(opA), .opB(opB), .outValid(outValid), .result(result)
);

// File: tb/pmul16_unit_tb.sv
module pmul16_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic [63:0] opA = '0, opB = '0;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  logic [63:0] expQ [$];
  logic [63:0] lastResult = '0;
  int cycleNow = 0;
  int issueCyc [$];
  bit done = 0;

  pmul16_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycleNow <= cycleNow + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R1: signed 16x16 lane products
  function automatic logic [31:0] lprod(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] x, y;
    x = {{16{a[15]}}, a};
    y = {{16{b[15]}}, b};
    return x * y;
  endfunction

  function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] p [4];
    logic [63:0] r;
    for (int i = 0; i < 4; i++) p[i] = lprod(a[16*i +: 16], b[16*i +: 16]);
    r = '0;
    case (op)
      2'b00: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];   // R2
      2'b01: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];  // R3
      2'b10: r = {p[2] + p[3], p[0] + p[1]};                           // R4
      default: r = '0;                                                  // R8
    endcase
    return r;
  endfunction

  // Driver: one issue per call, inputs changed on the falling edge
  task automatic issue(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    start = 1'b1; opcode = op; opA = a; opB = b;
    expQ.push_back(model(op, a, b));
    issueCyc.push_back(cycleNow);
    @(negedge clk);
    start = 1'b0; opA = '0; opB = '0; opcode = 2'b00;
  endtask

  task automatic burst(input logic [1:0] op [4], input logic [63:0] a [4], input logic [63:0] b [4]);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      start = 1'b1; opcode = op[k]; opA = a[k]; opB = b[k];
      expQ.push_back(model(op[k], a[k], b[k]));
      issueCyc.push_back(cycleNow);
    end
    @(negedge clk);
    start = 1'b0; opA = '0; opB = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (outValid) begin
          if (expQ.size() == 0) begin
            check("R6 unexpected valid", 64'd1, 64'd0);
          end else begin
            logic [63:0] e;
            int ic;
            e  = expQ.pop_front();
            ic = issueCyc.pop_front();
            // R6: issued in cycle ic (count at that negedge), result after two edges
            check("R6 latency", 64'(cycleNow - ic), 64'd2);
            check("R2/R3/R4/R8 result", result, e);
          end
        end else begin
          check("R7 hold", result, lastResult);
        end
        lastResult = result;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0]  ops [4];
    logic [63:0] as [4];
    logic [63:0] bs [4];
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid in reset", {63'd0, outValid}, 64'd0);
    check("R9 result in reset", result, 64'd0);
    rstN = 1'b1;
    idle(2);

    // R2 low halves, mixed signs
    issue(2'b00, 64'h0003_FFFF_1234_0002, 64'h0005_0002_0100_FFFD);
    idle(3);
    // R3 high halves
    issue(2'b01, 64'h7FFF_8000_1234_FFFF, 64'h7FFF_7FFF_5678_FFFF);
    idle(3);
    // R4 dot product, mixed signs
    issue(2'b10, 64'h0010_FFF0_0003_0004, 64'h0002_0003_FFFE_0005);
    idle(2);
    // R5 overflow corner: all -32768 in both pairs
    issue(2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
    idle(2);
    check("R5 overflow corner", lastResult, 64'h8000_0000_8000_0000);
    // R8 reserved opcode yields zero
    issue(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
    idle(3);
    // R6 back-to-back, all opcodes
    ops[0] = 2'b00; as[0] = 64'h8000_7FFF_0001_FFFF; bs[0] = 64'h8000_7FFF_FFFF_FFFF;
    ops[1] = 2'b01; as[1] = 64'h8000_7FFF_0001_FFFF; bs[1] = 64'h8000_7FFF_FFFF_FFFF;
    ops[2] = 2'b10; as[2] = 64'h7FFF_7FFF_8000_8000; bs[2] = 64'h7FFF_7FFF_7FFF_7FFF;
    ops[3] = 2'b11; as[3] = 64'h0101_0202_0303_0404; bs[3] = 64'h0505_0606_0707_0808;
    burst(ops, as, bs);
    idle(4);
    // R1 lane ordering: distinct lane values
    issue(2'b00, 64'h0004_0003_0002_0001, 64'h0010_0010_0010_0010);
    idle(2);
    check("R1 lane order", lastResult, 64'h0040_0030_0020_0010);
    idle(3);
    // R6 single issue count check: queue must be drained
    check("R6 queue drained", 64'(expQ.size()), 64'd0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule